// File: doc/BRIEF.md
# Chip-Select External Memory Controller

This block sits between an internal requester and an external parallel memory bus. It turns each read or write request into a bus cycle on one of four independently configured memory banks. Each request is decoded to a bank. The controller then drives that bank's active-low chip select, counts out the bank's programmed wait states, and drives the active-low byte-lane strobes. It raises a one-cycle acknowledge for every beat.

Each bank has its own configuration, supplied on static configuration inputs:
- an enable, plus a base tag and mask compared against the upper address bits;
- a port width of 32 or 16 bits;
- a strobe mode that chooses write-enable or byte-enable behaviour;
- a first-access wait count from 0 to 15;
- an inter-beat wait count from 0 to 3.

Byte ordering is big-endian throughout. Lane 0 carries bus bits 31:24, lane 1 bits 23:16, lane 2 bits 15:8 and lane 3 bits 7:0.

A request is accepted only while the controller is idle (`req_ready_o` high). Bursts are fixed at four beats of the bank's port width. The configuration must stay stable while a request is in flight.

Top module: `ebi_cs_ctrl`

## Requirements
- R1: A request hits bank i when bank i is enabled and its tag bits (address bits 31:16) match the base tag in every bit set in the mask. When several banks hit, the lowest-numbered bank is used, and only that bank's chip select asserts.
- R2: A request that hits no enabled bank is acknowledged with `err_o` high in the cycle right after acceptance, and no chip select or lane strobe asserts.
- R3: The chip select asserts in the cycle after acceptance. The first beat is acknowledged W cycles later, where W is the bank's first-access wait count (0 to 15); with W=0 the acknowledge falls in the first chip-select cycle.
- R4: A burst request (`req_burst_i`=1) performs four beats. Each later beat is acknowledged B+1 cycles after the previous one, where B is the bank's inter-beat wait count (0 to 3). Beat addresses start at the request address aligned to the port width and step by 4 (32-bit port) or 2 (16-bit port).
- R5: With the strobe mode bit at 0, lane strobes assert only on writes. With it at 1, they assert on reads and writes alike, over the same cycles.
- R6: On a 32-bit port, single accesses use these lanes (`req_size_i` 0 = byte, 1 = halfword, 2 = word): a byte at offset k uses lane k; a halfword uses lanes 0–1 (offset 0) or 2–3 (offset 2); a word or burst beat uses all four lanes. The bus address has bits 1:0 cleared, and write data is driven as given.
- R7: On a 16-bit port, lanes 2 and 3 never assert. A byte uses lane 0 or 1 according to address bit 0; halfwords, split words and burst beats use lanes 0 and 1. The beat's data travels on bus bits 31:16. Write data comes from `req_wdata_i[15:0]` when the beat address has bit 1 set, and from `req_wdata_i[31:16]` otherwise. The bus address has bit 0 cleared.
- R8: A non-burst word access to a 16-bit port becomes two beats, at the word-aligned address and then at that address plus 2, so the more significant half goes first. Each beat uses the full first-access wait count, so the second acknowledge comes W+1 cycles after the first.
- R9: The chip select stays asserted, on the same bank, from its first cycle until the final beat's acknowledge. In the next cycle the controller is idle with every chip select and strobe deasserted. `req_ready_o` is high only while idle, including during reset.
- R10: During each read beat's acknowledge cycle, `rdata_o` presents the data on `ebi_rdata_i`, and `ebi_rnw_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | NB | Per-bank enable |
| cfg_base_i | input | NB*DW | Per-bank base tag, bank i at [i*DW +: DW] |
| cfg_mask_i | input | NB*DW | Per-bank compare mask, same layout |
| cfg_ps16_i | input | NB | Per-bank port width: 1 = 16 bits, 0 = 32 bits |
| cfg_bemode_i | input | NB | Per-bank strobe mode: 1 = byte enable, 0 = write enable |
| cfg_wait_i | input | NB*WAIT_W | Per-bank first-access wait count |
| cfg_bwait_i | input | NB*BWAIT_W | Per-bank inter-beat wait count |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, request accepted |
| req_addr_i | input | 32 | Request byte address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| req_burst_i | input | 1 | Four-beat burst |
| req_wdata_i | input | 32 | Write data, big-endian positioned |
| ack_o | output | 1 | Beat complete (one cycle per beat) |
| err_o | output | 1 | No bank matched, with ack_o |
| rdata_o | output | 32 | Read data of the acknowledged beat |
| ebi_cs_n_o | output | NB | Chip selects, active low |
| ebi_lane_n_o | output | 4 | Lane strobes, active low, index = lane |
| ebi_rnw_o | output | 1 | Bus direction, 1 = read |
| ebi_addr_o | output | 32 | Bus beat address |
| ebi_wdata_o | output | 32 | Bus write data |
| ebi_rdata_i | input | 32 | Bus read data |

## Verification
Every acknowledge has a fixed due cycle. It falls W cycles after the accepting edge for a first beat and zero cycles after it for a decode miss. A later beat follows the previous acknowledge by B+1 cycles in a burst or W+1 cycles in a split word. The bench computes that absolute cycle number together with the expected chip select, strobes, address and data for every beat when it drives the request. The monitor compares everything at the falling edge where the acknowledge is seen. An acknowledge that comes early, comes late or is not expected is reported against the cycle count. One cycle after the last acknowledge, the bench checks that the bus is released and the controller is ready again.

// File: rtl/ebi_cs_pkg.sv
package ebi_cs_pkg;

  localparam int BURST_LEN = 4;
  localparam int BEATS_W   = $clog2(BURST_LEN);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_ERR  = 2'd2
  } state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

endpackage

// File: rtl/ebi_bank_decode.sv
module ebi_bank_decode #(
  parameter int NB = 4,
  parameter int DW = 16,
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [DW-1:0]    tag_i,
  input  logic [NB*DW-1:0] base_i,
  input  logic [NB*DW-1:0] mask_i,
  input  logic [NB-1:0]    en_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);

  logic [NB-1:0] match;

  for (genvar g = 0; g < NB; g++) begin : g_cmp
    assign match[g] = en_i[g] &&
                      (((tag_i ^ base_i[g*DW +: DW]) & mask_i[g*DW +: DW]) == '0);
  end

  // lowest index wins
  always_comb begin
    hit_o = |match;
    idx_o = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (match[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/ebi_beat_timer.sv
module ebi_beat_timer #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/ebi_lane_gen.sv
module ebi_lane_gen
  import ebi_cs_pkg::*;
(
  input  logic        ps16_i,
  input  logic [1:0]  size_i,
  input  logic        burst_i,
  input  logic [1:0]  lo_i,
  input  logic [31:0] word_i,
  output logic [3:0]  lanes_o,
  output logic [31:0] bus_o
);

  // bit i of lanes_o is lane i; lane 0 = bits 31:24
  always_comb begin
    if (ps16_i) begin
      if (burst_i || size_i != SZ_BYTE) lanes_o = 4'b0011;
      else                              lanes_o = lo_i[0] ? 4'b0010 : 4'b0001;
      bus_o = {(lo_i[1] ? word_i[15:0] : word_i[31:16]), 16'h0000};
    end else begin
      if (burst_i || size_i == SZ_WORD) lanes_o = 4'b1111;
      else if (size_i == SZ_HALF)       lanes_o = lo_i[1] ? 4'b1100 : 4'b0011;
      else                              lanes_o = 4'b0001 << lo_i;
      bus_o = word_i;
    end
  end

endmodule

// File: rtl/ebi_cs_ctrl.sv
module ebi_cs_ctrl
  import ebi_cs_pkg::*;
#(
  parameter int NB      = 4,
  parameter int DW      = 16,
  parameter int WAIT_W  = 4,
  parameter int BWAIT_W = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NB-1:0]         cfg_en_i,
  input  logic [NB*DW-1:0]      cfg_base_i,
  input  logic [NB*DW-1:0]      cfg_mask_i,
  input  logic [NB-1:0]         cfg_ps16_i,
  input  logic [NB-1:0]         cfg_bemode_i,
  input  logic [NB*WAIT_W-1:0]  cfg_wait_i,
  input  logic [NB*BWAIT_W-1:0] cfg_bwait_i,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [31:0]           req_addr_i,
  input  logic                  req_write_i,
  input  logic [1:0]            req_size_i,
  input  logic                  req_burst_i,
  input  logic [31:0]           req_wdata_i,
  output logic                  ack_o,
  output logic                  err_o,
  output logic [31:0]           rdata_o,
  output logic [NB-1:0]         ebi_cs_n_o,
  output logic [3:0]            ebi_lane_n_o,
  output logic                  ebi_rnw_o,
  output logic [31:0]           ebi_addr_o,
  output logic [31:0]           ebi_wdata_o,
  input  logic [31:0]           ebi_rdata_i
);

  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;

  state_e             state_q;
  logic [IDX_W-1:0]   bank_q;
  logic [31:0]        addr_q;
  logic [31:0]        word_q;
  logic               write_q;
  logic [1:0]         size_q;
  logic               burst_q;
  logic [BEATS_W-1:0] left_q;

  logic               dec_hit;
  logic [IDX_W-1:0]   dec_idx;
  logic               accept, busy, beat_done, beat_ack;
  logic               new_ps16, new_split;
  logic [WAIT_W-1:0]  new_wait;
  logic               cur_ps16, cur_be;
  logic [WAIT_W-1:0]  cur_wait;
  logic [BWAIT_W-1:0] cur_bwait;
  logic [31:0]        start_addr;
  logic [BEATS_W-1:0] start_left;
  logic               tmr_load;
  logic [WAIT_W-1:0]  tmr_val;
  logic [3:0]         lanes;
  logic [31:0]        bus_word;

  ebi_bank_decode #(.NB(NB), .DW(DW)) u_dec (
    .tag_i  (req_addr_i[31 -: DW]),
    .base_i (cfg_base_i),
    .mask_i (cfg_mask_i),
    .en_i   (cfg_en_i),
    .hit_o  (dec_hit),
    .idx_o  (dec_idx)
  );

  assign busy     = (state_q == ST_BEAT);
  assign accept   = req_valid_i && (state_q == ST_IDLE);
  assign beat_ack = busy && beat_done;

  assign new_ps16  = cfg_ps16_i[dec_idx];
  assign new_wait  = cfg_wait_i[dec_idx*WAIT_W +: WAIT_W];
  assign new_split = new_ps16 && (req_size_i == SZ_WORD) && !req_burst_i;

  assign cur_ps16  = cfg_ps16_i[bank_q];
  assign cur_be    = cfg_bemode_i[bank_q];
  assign cur_wait  = cfg_wait_i[bank_q*WAIT_W +: WAIT_W];
  assign cur_bwait = cfg_bwait_i[bank_q*BWAIT_W +: BWAIT_W];

  always_comb begin
    if (req_burst_i) begin
      start_addr = new_ps16 ? {req_addr_i[31:1], 1'b0} : {req_addr_i[31:2], 2'b00};
      start_left = BEATS_W'(BURST_LEN - 1);
    end else if (new_split) begin
      start_addr = {req_addr_i[31:2], 2'b00};
      start_left = BEATS_W'(1);
    end else begin
      start_addr = req_addr_i;
      start_left = '0;
    end
  end

  // one counter serves first-access and inter-beat waits
  assign tmr_load = (accept && dec_hit) || (beat_ack && left_q != '0);
  assign tmr_val  = accept  ? new_wait :
                    burst_q ? WAIT_W'(cur_bwait) : cur_wait;

  ebi_beat_timer #(.CW(WAIT_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (beat_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bank_q  <= '0;
      addr_q  <= '0;
      word_q  <= '0;
      write_q <= 1'b0;
      size_q  <= SZ_BYTE;
      burst_q <= 1'b0;
      left_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            if (dec_hit) begin
              state_q <= ST_BEAT;
              bank_q  <= dec_idx;
              addr_q  <= start_addr;
              word_q  <= req_wdata_i;
              write_q <= req_write_i;
              size_q  <= req_size_i;
              burst_q <= req_burst_i;
              left_q  <= start_left;
            end else begin
              state_q <= ST_ERR;
            end
          end
        end
        ST_BEAT: begin
          if (beat_done) begin
            if (left_q == '0) begin
              state_q <= ST_IDLE;
            end else begin
              left_q <= left_q - 1'b1;
              addr_q <= addr_q + (cur_ps16 ? 32'd2 : 32'd4);
            end
          end
        end
        ST_ERR:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  ebi_lane_gen u_lanes (
    .ps16_i  (cur_ps16),
    .size_i  (size_q),
    .burst_i (burst_q),
    .lo_i    (addr_q[1:0]),
    .word_i  (word_q),
    .lanes_o (lanes),
    .bus_o   (bus_word)
  );

  for (genvar g = 0; g < NB; g++) begin : g_cs
    assign ebi_cs_n_o[g] = !(busy && bank_q == IDX_W'(g));
  end

  assign ebi_lane_n_o = ~((busy && (write_q || cur_be)) ? lanes : 4'b0000);
  assign ebi_rnw_o    = !(busy && write_q);
  assign ebi_addr_o   = cur_ps16 ? {addr_q[31:1], 1'b0} : {addr_q[31:2], 2'b00};
  assign ebi_wdata_o  = (busy && write_q) ? bus_word : 32'h0;

  assign req_ready_o = (state_q == ST_IDLE);
  assign ack_o       = beat_ack || (state_q == ST_ERR);
  assign err_o       = (state_q == ST_ERR);
  assign rdata_o     = ebi_rdata_i;

endmodule

// File: rtl/ebi_cs_ctrl_chk.sv
module ebi_cs_ctrl_chk #(
  parameter int NB = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          ack_o,
  input logic          err_o,
  input logic [NB-1:0] ebi_cs_n_o,
  input logic [3:0]    ebi_lane_n_o,
  input logic          ebi_rnw_o,
  input logic [NB-1:0] cfg_ps16_i,
  input logic [NB-1:0] cfg_bemode_i
);

  logic cs_any, be_act, ps16_act;
  assign cs_any   = !(&ebi_cs_n_o);
  assign be_act   = |(~ebi_cs_n_o & cfg_bemode_i);
  assign ps16_act = |(~ebi_cs_n_o & cfg_ps16_i);

  // R1
  one_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~ebi_cs_n_o));

  // R2
  err_no_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ack_o && !cs_any && (&ebi_lane_n_o)));

  // R9
  idle_no_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!cs_any && !ack_o));

  // R9
  cs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_any && !ack_o) |=> $stable(ebi_cs_n_o));

  // R5
  we_read_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_any && ebi_rnw_o && !be_act) |-> (&ebi_lane_n_o));

  // R5
  lane_needs_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_any |-> (&ebi_lane_n_o));

  // R7
  narrow_lanes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps16_act |-> (ebi_lane_n_o[3:2] == 2'b11));

endmodule

bind ebi_cs_ctrl ebi_cs_ctrl_chk #(.NB(NB)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .ack_o        (ack_o),
  .err_o        (err_o),
  .ebi_cs_n_o   (ebi_cs_n_o),
  .ebi_lane_n_o (ebi_lane_n_o),
  .ebi_rnw_o    (ebi_rnw_o),
  .cfg_ps16_i   (cfg_ps16_i),
  .cfg_bemode_i (cfg_bemode_i)
);

// File: tb/ebi_cs_ctrl_tb_top.sv
`timescale 1ns/100ps
module ebi_cs_ctrl_tb_top;

  localparam logic [31:0] PAT = 32'h5A5A_0F0F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_en = '0;
  logic [63:0] cfg_base = '0, cfg_mask = '0;
  logic [3:0]  cfg_ps16 = '0, cfg_be = '0;
  logic [15:0] cfg_wait = '0;
  logic [7:0]  cfg_bwait = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_size = '0;
  logic        req_ready, ack, err, rnw;
  logic [31:0] rdata, baddr, bwdata, brdata;
  logic [3:0]  cs_n, lane_n;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  typedef struct {
    int          t;
    bit          err;
    logic [3:0]  cs;
    logic [3:0]  lane;
    logic [31:0] addr;
    bit          rnw;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign brdata = baddr ^ PAT;

  ebi_cs_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_en_i(cfg_en), .cfg_base_i(cfg_base), .cfg_mask_i(cfg_mask),
    .cfg_ps16_i(cfg_ps16), .cfg_bemode_i(cfg_be),
    .cfg_wait_i(cfg_wait), .cfg_bwait_i(cfg_bwait),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_write_i(req_write), .req_size_i(req_size), .req_burst_i(req_burst),
    .req_wdata_i(req_wdata),
    .ack_o(ack), .err_o(err), .rdata_o(rdata),
    .ebi_cs_n_o(cs_n), .ebi_lane_n_o(lane_n), .ebi_rnw_o(rnw),
    .ebi_addr_o(baddr), .ebi_wdata_o(bwdata), .ebi_rdata_i(brdata)
  );

  task automatic check(bit ok, string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic set_bank(int i, bit en, logic [15:0] base, logic [15:0] mask,
                          bit ps, bit be, logic [3:0] w, logic [1:0] bw);
    cfg_en[i] = en;
    cfg_base[i*16 +: 16] = base;
    cfg_mask[i*16 +: 16] = mask;
    cfg_ps16[i] = ps;
    cfg_be[i] = be;
    cfg_wait[i*4 +: 4] = w;
    cfg_bwait[i*2 +: 2] = bw;
  endtask

  function automatic logic [3:0] exp_lanes(bit ps, logic [1:0] sz, bit bu, logic [1:0] lo);
    if (ps) return (bu || sz != 2'd0) ? 4'b0011 : (lo[0] ? 4'b0010 : 4'b0001);
    if (bu || sz == 2'd2) return 4'b1111;
    if (sz == 2'd1) return lo[1] ? 4'b1100 : 4'b0011;
    return 4'b0001 << lo;
  endfunction

  // driver: computes expected beats, pushes them, drives the request
  task automatic issue(string tag, logic [31:0] a, bit wr, logic [1:0] sz, bit bu,
                       logic [31:0] wd);
    int b, nb, t, w, bw;
    bit ps, be;
    logic [31:0] a0, ba;
    exp_t e;
    @(negedge clk);
    check(req_ready === 1'b1,
          $sformatf("%s ready before request act=%b exp=1", tag, req_ready));
    b = -1;
    for (int i = 0; i < 4; i++)
      if (b < 0 && cfg_en[i] &&
          (((a[31:16] ^ cfg_base[i*16 +: 16]) & cfg_mask[i*16 +: 16]) == 16'h0)) b = i;
    t = cyc + 1;
    if (b < 0) begin
      e.t = t; e.err = 1'b1; e.cs = 4'hF; e.lane = 4'hF;
      e.addr = '0; e.rnw = 1'b1; e.data = '0; e.tag = tag;
      q.push_back(e);
    end else begin
      ps = cfg_ps16[b]; be = cfg_be[b];
      w  = int'(cfg_wait[b*4 +: 4]); bw = int'(cfg_bwait[b*2 +: 2]);
      nb = bu ? 4 : ((ps && sz == 2'd2) ? 2 : 1);
      if (bu)          a0 = ps ? {a[31:1], 1'b0} : {a[31:2], 2'b00};
      else if (nb == 2) a0 = {a[31:2], 2'b00};
      else             a0 = a;
      for (int k = 0; k < nb; k++) begin
        ba  = a0 + 32'(k * (ps ? 2 : 4));
        t   = (k == 0) ? t + w : t + (bu ? bw : w) + 1;
        e.t = t; e.err = 1'b0; e.tag = tag;
        e.cs   = ~(4'b0001 << b);
        e.lane = ~((wr || be) ? exp_lanes(ps, sz, bu, ba[1:0]) : 4'b0000);
        e.addr = ps ? {ba[31:1], 1'b0} : {ba[31:2], 2'b00};
        e.rnw  = !wr;
        if (wr) e.data = ps ? {(ba[1] ? wd[15:0] : wd[31:16]), 16'h0} : wd;
        else    e.data = e.addr ^ PAT;
        q.push_back(e);
      end
    end
    req_valid = 1'b1; req_addr = a; req_write = wr; req_size = sz;
    req_burst = bu; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    do @(posedge clk); while (q.size() != 0);
    @(negedge clk);
    // R9: released one cycle after final ack
    check(req_ready === 1'b1 && cs_n === 4'hF && lane_n === 4'hF,
          $sformatf("R9 %s release ready=%b cs=%b lane=%b exp ready=1 cs=1111 lane=1111",
                    tag, req_ready, cs_n, lane_n));
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (ack) begin
        if (q.size() == 0) begin
          check(1'b0, $sformatf("R3 unexpected ack at cycle %0d exp none", cyc));
        end else begin
          exp_t e;
          bit ok;
          e = q.pop_front();
          ok = (cyc == e.t) && (err === e.err) && (cs_n === e.cs);
          if (!e.err)
            ok = ok && (lane_n === e.lane) && (baddr === e.addr) && (rnw === e.rnw) &&
                 (e.rnw ? (rdata === e.data) : (bwdata === e.data));
          check(ok, $sformatf(
            "%s cyc=%0d/%0d err=%b/%b cs=%b/%b lane=%b/%b addr=%h/%h rnw=%b/%b data=%h/%h (act/exp)",
            e.tag, cyc, e.t, err, e.err, cs_n, e.cs, lane_n, e.lane, baddr, e.addr,
            rnw, e.rnw, (e.rnw ? rdata : bwdata), e.data));
        end
      end else if (q.size() != 0 && cyc > q[0].t) begin
        exp_t e;
        e = q.pop_front();
        check(1'b0, $sformatf("%s missing ack at cycle %0d act=none", e.tag, e.t));
      end
    end
  end

  initial begin
    while (cyc < 20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=%0d cycles exp<20000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    set_bank(0, 1, 16'h1000, 16'hF000, 0, 0, 4'd2,  2'd1);
    set_bank(1, 1, 16'h2000, 16'hF000, 1, 1, 4'd0,  2'd0);
    set_bank(2, 1, 16'h3000, 16'hF000, 0, 1, 4'd15, 2'd3);
    set_bank(3, 1, 16'h0000, 16'h8000, 1, 0, 4'd1,  2'd2);
    repeat (3) @(negedge clk);
    // R9: reset state
    check(req_ready === 1'b1 && cs_n === 4'hF && lane_n === 4'hF && ack === 1'b0,
          $sformatf("R9 reset ready=%b cs=%b lane=%b ack=%b exp 1/1111/1111/0",
                    req_ready, cs_n, lane_n, ack));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    issue("R1_R3 bank0 word write W=2",   32'h1000_0000, 1, 2'd2, 0, 32'h1122_3344);
    issue("R5 bank0 WE-mode read quiet",  32'h1000_0010, 0, 2'd2, 0, 32'h0);
    issue("R6 bank0 byte lane3",          32'h1000_0003, 1, 2'd0, 0, 32'h0000_00AB);
    issue("R6 bank0 byte lane1",          32'h1000_0101, 1, 2'd0, 0, 32'h00CD_0000);
    issue("R6 bank0 half lanes2-3",       32'h1000_0002, 1, 2'd1, 0, 32'h0000_BEEF);
    issue("R4 bank0 burst read B=1",      32'h1000_0024, 0, 2'd2, 1, 32'h0);
    issue("R8 bank1 split word write",    32'h2000_0100, 1, 2'd2, 0, 32'hAABB_CCDD);
    issue("R10_R5 bank1 BE half read",    32'h2000_0106, 0, 2'd1, 0, 32'h0);
    issue("R7 bank1 byte write",          32'h2000_0105, 1, 2'd0, 0, 32'h00EE_0000);
    issue("R4 bank1 burst read B=0",      32'h2000_0203, 0, 2'd2, 1, 32'h0);
    issue("R3_R10 bank2 read W=15",       32'h3000_0040, 0, 2'd2, 0, 32'h0);
    issue("R4 bank2 burst write B=3",     32'h3000_0080, 1, 2'd2, 1, 32'h1357_9BDF);
    issue("R1 overlap picks bank0",       32'h1000_0200, 0, 2'd2, 0, 32'h0);
    issue("R1 bank3 match",               32'h5000_0000, 0, 2'd1, 0, 32'h0);
    issue("R8 bank3 split write W=1",     32'h5000_0008, 1, 2'd2, 0, 32'hCAFE_F00D);
    issue("R2 no bank match",             32'h9000_0000, 0, 2'd2, 0, 32'h0);
    cfg_en[3] = 1'b0;
    issue("R2 disabled bank",             32'h5000_0000, 1, 2'd2, 0, 32'h1234_5678);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule